// File: doc/BRIEF.md
# Receive-line wake-up detector

This block watches the receive line of an asynchronous serial port while a software-controlled wake enable bit is set. It lets a sleeping system be roused by line activity even when the baud generator is stopped. Once armed, it holds the normal character receiver inhibited and waits for a falling edge on the line. An asynchronous latch catches that edge, so no functional clock is needed to detect it. The latch output is then resynchronized into the running clock domain. There it sets the receive interrupt flag and raises a wake request.

After the event the block waits for the line to return high, which marks the end of the break. It then clears the enable bit itself and releases the receiver inhibit, and the normal receiver is idle again, ready for the next character. The block does not time the low period: any falling edge counts, even one far shorter than a clock period. The enable bit only has an effect in asynchronous mode. A separate registered status output reports whether the normal receiver is idle, so software can check it before arming.

Top module: `rx_wake_detector`

## Requirements
- R1: After a synchronous reset, `wake_en`, `rx_inhibit`, `rx_irq` and `wake_req` are 0 and `rx_idle` is 1.
- R2: A write (`wen_wr`=1) in asynchronous mode (`async_mode`=1) loads `wen_data` into `wake_en` at the next rising edge, and `rx_inhibit` follows it at that same edge.
- R3: In synchronous mode (`async_mode`=0) the enable bit can still be written and read back, but `rx_inhibit` stays 0 and falling edges raise no interrupt. Leaving asynchronous mode while armed drops `rx_inhibit` at the next edge.
- R4: While armed, a falling edge on `rx_in` between two clock edges sets `rx_irq` and `wake_req` at the third rising edge after it.
- R5: A receive-buffer read (`rxbuf_rd`=1) with no coincident wake event clears `rx_irq` and `wake_req` at the next edge. Until then `wake_req` stays high.
- R6: When a wake event and a buffer read fall in the same cycle, the event wins and `rx_irq` and `wake_req` stay set.
- R7: After the event, the third rising edge after `rx_in` returns high clears `wake_en` and `rx_inhibit`. `rx_irq` keeps its value.
- R8: The low time is not measured. A low pulse shorter than a clock period still sets `rx_irq` at the third edge, and `wake_en` clears one edge later.
- R9: A falling edge while not armed (`wake_en`=0) changes no output.
- R10: `rx_idle` is the complement of `rcv_active`, registered by one edge.
- R11: Writing 0 to the enable bit while armed disarms the block. A later falling edge raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| async_mode | input | 1 | 1 = asynchronous mode, 0 = synchronous mode |
| rcv_active | input | 1 | Normal receiver is in the middle of a character |
| wen_wr | input | 1 | Write strobe for the wake enable bit |
| wen_data | input | 1 | Value written to the wake enable bit |
| rxbuf_rd | input | 1 | Receive-buffer read strobe; clears the interrupt |
| wake_en | output | 1 | Wake enable bit readback (self-clearing) |
| rx_inhibit | output | 1 | Blocks normal character reception while armed |
| rx_irq | output | 1 | Receive interrupt flag |
| wake_req | output | 1 | Wake request, held until the interrupt is cleared |
| rx_idle | output | 1 | Normal receiver idle status |

## Verification
A wake event, meaning the resynchronized falling edge reaching the controller, can land in the same clock cycle as a receive-buffer read strobe. The bench provokes this by asserting `rxbuf_rd` in exactly the cycle that precedes the third edge after a falling edge, while `rx_irq` is already set from an earlier event. It judges the outcome by expecting both `rx_irq` and `wake_req` still high after that edge. A later lone read must then clear them.

// File: rtl/rwk_pkg.sv
package rwk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BREAK = 2'd2
  } rwk_state_t;

  localparam int unsigned RWK_MIN_SYNC = 2;
endpackage

// File: rtl/rwk_sync.sv
module rwk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rwk_edge_capture.sv
module rwk_edge_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic arm,
  output logic fall_pulse,
  output logic rx_level
);
  logic clr_lat;
  logic fall_lat;
  logic fall_sync;
  logic fall_sync_d;

  // The latch is released only by a registered arm flag, so the clear is glitch free.
  assign clr_lat = ~arm;

  always_ff @(negedge rx_in or posedge clr_lat) begin
    if (clr_lat) fall_lat <= 1'b0;
    else         fall_lat <= 1'b1;
  end

  rwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_fall_sync (
    .clk(clk), .rst(rst), .d(fall_lat), .q(fall_sync)
  );

  rwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_level_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) fall_sync_d <= 1'b0;
    else     fall_sync_d <= fall_sync;
  end

  assign fall_pulse = fall_sync & ~fall_sync_d;

  // R8: a captured edge reaches the clock domain as a single-cycle pulse
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/rwk_ctrl.sv
module rwk_ctrl
  import rwk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic wen_wr,
  input  logic wen_data,
  input  logic fall_pulse,
  input  logic rx_level,
  output logic wake_evt,
  output logic arm,
  output logic wake_en,
  output logic rx_inhibit
);
  rwk_state_t state_q, state_n;
  logic en_q, en_n;
  logic inhibit_q;
  logic arm_q;
  logic active;

  always_comb begin
    en_n = en_q;
    if (state_q == ST_BREAK && rx_level) en_n = 1'b0;
    if (wen_wr) en_n = wen_data;
  end

  assign active   = en_n & async_mode;
  assign wake_evt = (state_q == ST_ARMED) & active & fall_pulse;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (active) state_n = ST_ARMED;
      ST_ARMED: begin
        if (!active)        state_n = ST_IDLE;
        else if (fall_pulse) state_n = ST_BREAK;
      end
      ST_BREAK: if (rx_level || !active) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      en_q      <= 1'b0;
      inhibit_q <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      en_q      <= en_n;
      inhibit_q <= active;
      arm_q     <= (state_n == ST_ARMED);
    end
  end

  assign arm        = arm_q;
  assign wake_en    = en_q;
  assign rx_inhibit = inhibit_q;

  // R3: synchronous mode never leaves the receiver inhibited
  p_sync_no_inhibit_r3: assert property (@(posedge clk) disable iff (rst)
    !async_mode |=> (!rx_inhibit && state_q != ST_ARMED));

  // R7: end of break with no software write clears the enable bit
  p_break_end_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BREAK && rx_level && !wen_wr) |=> !wake_en);

  // R11: disarming write leaves the block unarmed
  p_disarm_r11: assert property (@(posedge clk) disable iff (rst)
    (wen_wr && !wen_data) |=> (!arm && !wake_en));
endmodule

// File: rtl/rwk_flags.sv
module rwk_flags (
  input  logic clk,
  input  logic rst,
  input  logic wake_evt,
  input  logic rxbuf_rd,
  input  logic rcv_active,
  output logic rx_irq,
  output logic wake_req,
  output logic rx_idle
);
  logic irq_q, wake_q, idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      if (wake_evt) begin
        irq_q  <= 1'b1;
        wake_q <= 1'b1;
      end else if (rxbuf_rd) begin
        irq_q  <= 1'b0;
        wake_q <= 1'b0;
      end
      idle_q <= ~rcv_active;
    end
  end

  assign rx_irq   = irq_q;
  assign wake_req = wake_q;
  assign rx_idle  = idle_q;

  // R5: a lone read clears the interrupt
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rxbuf_rd && !wake_evt) |=> !rx_irq);

  // R5: wake request holds until a read
  p_wake_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !rxbuf_rd) |=> wake_req);

  // R6: event beats a coincident read
  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wake_evt && rxbuf_rd) |=> (rx_irq && wake_req));
endmodule

// File: rtl/rx_wake_detector.sv
module rx_wake_detector #(
  parameter int unsigned SYNC_STAGES = rwk_pkg::RWK_MIN_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic async_mode,
  input  logic rcv_active,
  input  logic wen_wr,
  input  logic wen_data,
  input  logic rxbuf_rd,
  output logic wake_en,
  output logic rx_inhibit,
  output logic rx_irq,
  output logic wake_req,
  output logic rx_idle
);
  logic fall_pulse;
  logic rx_level;
  logic wake_evt;
  logic arm;

  rwk_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst(rst), .rx_in(rx_in), .arm(arm),
    .fall_pulse(fall_pulse), .rx_level(rx_level)
  );

  rwk_ctrl i_ctrl (
    .clk(clk), .rst(rst), .async_mode(async_mode),
    .wen_wr(wen_wr), .wen_data(wen_data),
    .fall_pulse(fall_pulse), .rx_level(rx_level),
    .wake_evt(wake_evt), .arm(arm),
    .wake_en(wake_en), .rx_inhibit(rx_inhibit)
  );

  rwk_flags i_flags (
    .clk(clk), .rst(rst), .wake_evt(wake_evt), .rxbuf_rd(rxbuf_rd),
    .rcv_active(rcv_active),
    .rx_irq(rx_irq), .wake_req(wake_req), .rx_idle(rx_idle)
  );

  // R9: the interrupt only rises after a cycle spent armed
  p_irq_needs_arm_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(rx_inhibit));

  // R4: interrupt and wake request rise together
  p_irq_wake_together_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> wake_req);
endmodule

// File: tb/test_rx_wake_detector.sv
`timescale 1ns/1ps
module test_rx_wake_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic async_mode = 1'b1;
  logic rcv_active = 1'b0;
  logic wen_wr = 1'b0;
  logic wen_data = 1'b0;
  logic rxbuf_rd = 1'b0;
  logic wake_en, rx_inhibit, rx_irq, wake_req, rx_idle;

  always #2 clk = ~clk;

  rx_wake_detector i_rx_wake_detector (
    .clk(clk), .rst(rst), .rx_in(rx_in), .async_mode(async_mode),
    .rcv_active(rcv_active), .wen_wr(wen_wr), .wen_data(wen_data),
    .rxbuf_rd(rxbuf_rd), .wake_en(wake_en), .rx_inhibit(rx_inhibit),
    .rx_irq(rx_irq), .wake_req(wake_req), .rx_idle(rx_idle)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected {wake_en, rx_inhibit, rx_irq, wake_req, rx_idle}
  logic [4:0] q_val[$];
  string      q_tag[$];

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expectation for the outputs right after the next rising edge
  task automatic expect_out(string tag, logic en, logic inh, logic irq, logic wk, logic idle);
    q_val.push_back({en, inh, irq, wk, idle});
    q_tag.push_back(tag);
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    while (q_val.size() > 0) begin
      logic [4:0] e;
      logic [4:0] a;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      a = {wake_en, rx_inhibit, rx_irq, wake_req, rx_idle};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual en/inh/irq/wake/idle=%b expected=%b at %0t", t, a, e, $time);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic arm_block();
    wen_wr = 1'b1; wen_data = 1'b1;
    tick();
    wen_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    expect_out("R1 reset", 0, 0, 0, 0, 1);
    tick();

    // R10 idle status
    rcv_active = 1'b1;
    expect_out("R10 busy", 0, 0, 0, 0, 0);
    tick();
    rcv_active = 1'b0;
    expect_out("R10 idle", 0, 0, 0, 0, 1);
    tick();

    // R9 fall while unarmed
    rx_in = 1'b0;
    tick(4);
    expect_out("R9 unarmed fall", 0, 0, 0, 0, 1);
    tick();
    rx_in = 1'b1;
    tick(3);

    // R3 synchronous mode
    async_mode = 1'b0;
    wen_wr = 1'b1; wen_data = 1'b1;
    expect_out("R3 sync write", 1, 0, 0, 0, 1);
    tick();
    wen_wr = 1'b0;
    rx_in = 1'b0;
    tick(4);
    expect_out("R3 sync fall ignored", 1, 0, 0, 0, 1);
    tick();
    rx_in = 1'b1;
    tick(3);
    wen_wr = 1'b1; wen_data = 1'b0;
    tick();
    wen_wr = 1'b0;

    // R2 arm in asynchronous mode
    async_mode = 1'b1;
    wen_wr = 1'b1; wen_data = 1'b1;
    expect_out("R2 arm", 1, 1, 0, 0, 1);
    tick();
    wen_wr = 1'b0;

    // R4 wake event latency
    rx_in = 1'b0;
    tick();
    expect_out("R4 before third edge", 1, 1, 0, 0, 1);
    tick();
    expect_out("R4 third edge", 1, 1, 1, 1, 1);
    tick();

    // R7 break end
    tick(2);
    expect_out("R7 held low", 1, 1, 1, 1, 1);
    tick();
    rx_in = 1'b1;
    expect_out("R7 rise edge1", 1, 1, 1, 1, 1);
    tick();
    expect_out("R7 rise edge2", 1, 1, 1, 1, 1);
    tick();
    expect_out("R7 enable cleared", 0, 0, 1, 1, 1);
    tick();

    // R5 read clears
    rxbuf_rd = 1'b1;
    expect_out("R5 read clears", 0, 0, 0, 0, 1);
    tick();
    rxbuf_rd = 1'b0;

    // R8 glitch-short low pulse
    arm_block();
    rx_in = 1'b0;
    #1;
    rx_in = 1'b1;
    tick(2);
    expect_out("R8 short pulse irq", 1, 1, 1, 1, 1);
    tick();
    expect_out("R8 short pulse ends", 0, 0, 1, 1, 1);
    tick();

    // R6 event coincides with read
    arm_block();
    rx_in = 1'b0;
    tick(2);
    rxbuf_rd = 1'b1;
    expect_out("R6 event beats read", 1, 1, 1, 1, 1);
    tick();
    expect_out("R5 later read", 1, 1, 0, 0, 1);
    tick();
    rxbuf_rd = 1'b0;
    rx_in = 1'b1;
    tick(3);
    expect_out("R7 after coincidence", 0, 0, 0, 0, 1);
    tick();

    // R3 leaving asynchronous mode while armed
    arm_block();
    async_mode = 1'b0;
    expect_out("R3 mode drop", 1, 0, 0, 0, 1);
    tick();
    async_mode = 1'b1;
    expect_out("R3 mode back", 1, 1, 0, 0, 1);
    tick();

    // R11 software disarm
    wen_wr = 1'b1; wen_data = 1'b0;
    expect_out("R11 disarm", 0, 0, 0, 0, 1);
    tick();
    wen_wr = 1'b0;
    rx_in = 1'b0;
    tick(4);
    expect_out("R11 fall after disarm", 0, 0, 0, 0, 1);
    tick();
    rx_in = 1'b1;
    tick(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule